// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Interconnect

This block connects N requesting processor ports to N memory ports through log2(N) columns of two-by-two switching cells. Before each column, the links are rewired by a perfect shuffle: link index i moves to the index given by rotating i left by one bit. No routing table is stored anywhere. Each request carries the label of the memory port it is going to, and every cell steers the request using one bit of that label.

Two requests in the same cycle can need the same output of the same cell, even when their destinations differ. In that case the network has an internal collision. One request goes through and the other is refused for that cycle. All routing is combinational. The delivered payloads, the grants and the blocked flags are registered, so they appear one clock after the request. Resending a refused request is left to the sources.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, `out_valid`, `grant` and `blocked` are all zero.
- R2: A request presented alone, from any source to any destination `d`, is granted. Its payload appears unchanged on output port `d`, with `out_valid[d]` high, exactly one clock after the request.
- R3: Column k (k = 0 is the first column) steers on destination bit log2(N)-1-k, with the most significant bit used first. A bit value of 0 selects the cell's even output and 1 selects its odd output. As a result, a conflict-free pattern such as the identity delivers every request to the port named by its label.
- R4: When both inputs of a cell ask for the same output, the request on the even-numbered input link goes through. The request on the odd-numbered link is dropped for that cycle and produces no output valid.
- R5: Two requests with different destination labels can collide inside the network. The loser is refused by the same rule as in R4.
- R6: One clock after a request, the source sees exactly one of `grant` or `blocked` set. A source that presented no request sees neither. A destination label sent with a clear valid bit has no effect.
- R7: The number of `out_valid` bits set always equals the number of `grant` bits set.
- R8: A cycle with no request produces no `out_valid` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | N | Request present, one bit per source |
| req_dest | input | N*log2(N) | Destination label per source; source s uses bits [s*log2(N) +: log2(N)] |
| req_data | input | N*DW | Payload per source; source s uses bits [s*DW +: DW] |
| out_valid | output | N | Payload delivered on this memory port |
| out_data | output | N*DW | Delivered payload per memory port; port p uses bits [p*DW +: DW] |
| grant | output | N | The source's request of the previous cycle went through |
| blocked | output | N | The source's request of the previous cycle was refused |

## Verification
The properties assume that `req_valid` is held at zero throughout reset. They also assume that all request inputs are steady around each rising edge, because the registered flags are compared with the request that was captured one clock earlier. The bench drives every input on the falling edge and keeps all requests idle until reset has been released for a few cycles. The stimulus includes lone requests, full permutations, shared destinations, internal collisions between different labels, and idle cycles that carry garbage labels.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // Perfect shuffle: rotate a link index left by one bit within 'bits' bits.
  function automatic int unsigned shuffle_idx(int unsigned idx, int unsigned bits);
    int unsigned top_bit;
    top_bit = (idx >> (bits - 1)) & 1;
    return ((idx << 1) | top_bit) & ((1 << bits) - 1);
  endfunction
endpackage

// File: rtl/omega_cell.sv
module omega_cell #(
  parameter int LGN = 3,
  parameter int DW  = 8,
  parameter int SEL = 0
) (
  input  logic           up_v,
  input  logic [LGN-1:0] up_dest,
  input  logic [LGN-1:0] up_src,
  input  logic [DW-1:0]  up_data,
  input  logic           lo_v,
  input  logic [LGN-1:0] lo_dest,
  input  logic [LGN-1:0] lo_src,
  input  logic [DW-1:0]  lo_data,
  output logic [1:0]     o_v,
  output logic [LGN-1:0] o_dest [2],
  output logic [LGN-1:0] o_src  [2],
  output logic [DW-1:0]  o_data [2]
);
  logic up_dir, lo_dir, clash;

  assign up_dir = up_dest[SEL];
  assign lo_dir = lo_dest[SEL];
  assign clash  = up_v && lo_v && (up_dir == lo_dir);

  always_comb begin
    o_v = '0;
    for (int p = 0; p < 2; p++) begin
      o_dest[p] = '0;
      o_src[p]  = '0;
      o_data[p] = '0;
    end
    // The even input always keeps its chosen output.
    if (up_v) begin
      o_v[up_dir]    = 1'b1;
      o_dest[up_dir] = up_dest;
      o_src[up_dir]  = up_src;
      o_data[up_dir] = up_data;
    end
    // The odd input is dropped when it collides with the even one.
    if (lo_v && !clash) begin
      o_v[lo_dir]    = 1'b1;
      o_dest[lo_dir] = lo_dest;
      o_src[lo_dir]  = lo_src;
      o_data[lo_dir] = lo_data;
    end
  end
endmodule

// File: rtl/omega_column.sv
module omega_column #(
  parameter int N     = 8,
  parameter int LGN   = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0
) (
  input  logic [N-1:0]   in_v,
  input  logic [LGN-1:0] in_dest [N],
  input  logic [LGN-1:0] in_src  [N],
  input  logic [DW-1:0]  in_data [N],
  output logic [N-1:0]   out_v,
  output logic [LGN-1:0] out_dest [N],
  output logic [LGN-1:0] out_src  [N],
  output logic [DW-1:0]  out_data [N]
);
  import omega_pkg::*;

  localparam int CELLS   = N / 2;
  localparam int SEL_BIT = LGN - 1 - STAGE;

  logic [N-1:0]   sh_v;
  logic [LGN-1:0] sh_dest [N];
  logic [LGN-1:0] sh_src  [N];
  logic [DW-1:0]  sh_data [N];

  for (genvar i = 0; i < N; i++) begin : g_shuffle
    assign sh_v[shuffle_idx(i, LGN)]    = in_v[i];
    assign sh_dest[shuffle_idx(i, LGN)] = in_dest[i];
    assign sh_src[shuffle_idx(i, LGN)]  = in_src[i];
    assign sh_data[shuffle_idx(i, LGN)] = in_data[i];
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [1:0]     c_v;
    logic [LGN-1:0] c_dest [2];
    logic [LGN-1:0] c_src  [2];
    logic [DW-1:0]  c_data [2];

    omega_cell #(.LGN(LGN), .DW(DW), .SEL(SEL_BIT)) u_cell (
      .up_v   (sh_v[2*c]),
      .up_dest(sh_dest[2*c]),
      .up_src (sh_src[2*c]),
      .up_data(sh_data[2*c]),
      .lo_v   (sh_v[2*c+1]),
      .lo_dest(sh_dest[2*c+1]),
      .lo_src (sh_src[2*c+1]),
      .lo_data(sh_data[2*c+1]),
      .o_v    (c_v),
      .o_dest (c_dest),
      .o_src  (c_src),
      .o_data (c_data)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
      assign out_v[2*c+p]    = c_v[p];
      assign out_dest[2*c+p] = c_dest[p];
      assign out_src[2*c+p]  = c_src[p];
      assign out_data[2*c+p] = c_data[p];
    end
  end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N*LGN-1:0] req_dest,
  input  logic [N*DW-1:0] req_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [N-1:0]    grant,
  output logic [N-1:0]    blocked
);
  logic [N-1:0]   lk_v    [LGN+1];
  logic [LGN-1:0] lk_dest [LGN+1][N];
  logic [LGN-1:0] lk_src  [LGN+1][N];
  logic [DW-1:0]  lk_data [LGN+1][N];

  for (genvar s = 0; s < N; s++) begin : g_entry
    assign lk_dest[0][s] = req_dest[s*LGN +: LGN];
    assign lk_src[0][s]  = LGN'(s);
    assign lk_data[0][s] = req_data[s*DW +: DW];
  end
  assign lk_v[0] = req_valid;

  for (genvar k = 0; k < LGN; k++) begin : g_col
    omega_column #(.N(N), .LGN(LGN), .DW(DW), .STAGE(k)) u_col (
      .in_v    (lk_v[k]),
      .in_dest (lk_dest[k]),
      .in_src  (lk_src[k]),
      .in_data (lk_data[k]),
      .out_v   (lk_v[k+1]),
      .out_dest(lk_dest[k+1]),
      .out_src (lk_src[k+1]),
      .out_data(lk_data[k+1])
    );
  end

  // Next-state: map survivors back to their sources.
  logic [N-1:0] nxt_grant, nxt_blocked;
  always_comb begin
    nxt_grant = '0;
    for (int j = 0; j < N; j++)
      if (lk_v[LGN][j]) nxt_grant[lk_src[LGN][j]] = 1'b1;
    nxt_blocked = req_valid & ~nxt_grant;
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      grant     <= '0;
      blocked   <= '0;
    end else begin
      out_valid <= lk_v[LGN];
      grant     <= nxt_grant;
      blocked   <= nxt_blocked;
    end
  end

  // Payload registers, loaded only on delivery.
  logic [DW-1:0] data_q [N];
  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++)
      if (lk_v[LGN][j]) data_q[j] <= lk_data[LGN][j];
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    assign out_data[j*DW +: DW] = data_q[j];
  end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LGN = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [N*LGN-1:0] req_dest,
  input logic [N*DW-1:0] req_data,
  input logic [N-1:0]    out_valid,
  input logic [N*DW-1:0] out_data,
  input logic [N-1:0]    grant,
  input logic [N-1:0]    blocked
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R6
  grant_or_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((grant | blocked) == $past(req_valid)));

  // R7
  delivery_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(grant));

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ($past(req_valid) == '0)) |-> (out_valid == '0));

  // R2
  lone_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ($countones($past(req_valid)) == 1)) |-> (grant == $past(req_valid)));
endmodule

bind omega_net omega_net_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;
  localparam int N   = 8;
  localparam int DW  = 8;
  localparam int LGN = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N*LGN-1:0] req_dest;
  logic [N*DW-1:0] req_data;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    grant;
  logic [N-1:0]    blocked;

  omega_net #(.N(N), .DW(DW)) i_omega_net (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [N-1:0]    v;
    logic [N-1:0]    g;
    logic [N-1:0]    b;
    logic [N*DW-1:0] d;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int dst_a [N];
  logic [DW-1:0] dat_a [N];

  function automatic int shuf(int i);
    return ((i << 1) | (i >> (LGN - 1))) & (N - 1);
  endfunction

  function automatic int dbit(int src, int k);
    return (dst_a[src] >> (LGN - 1 - k)) & 1;
  endfunction

  // Driver: apply one cycle of requests and queue the expected result.
  task automatic send(input logic [N-1:0] v, input string tag);
    int occ [N];
    int sh [N];
    exp_t e;
    @(negedge clk);
    req_valid = v;
    for (int s = 0; s < N; s++) begin
      req_dest[s*LGN +: LGN] = LGN'(dst_a[s]);
      req_data[s*DW +: DW]   = dat_a[s];
      occ[s] = v[s] ? s : -1;
    end
    for (int k = 0; k < LGN; k++) begin
      for (int i = 0; i < N; i++) sh[shuf(i)] = occ[i];
      for (int i = 0; i < N; i++) occ[i] = -1;
      for (int c = 0; c < N/2; c++) begin
        int u, l;
        u = sh[2*c];
        l = sh[2*c+1];
        if (u >= 0) occ[2*c + dbit(u, k)] = u;
        if (l >= 0 && !(u >= 0 && dbit(u, k) == dbit(l, k)))
          occ[2*c + dbit(l, k)] = l;
      end
    end
    e.v = '0; e.g = '0; e.d = '0; e.tag = tag;
    for (int j = 0; j < N; j++) begin
      if (occ[j] >= 0) begin
        e.v[j] = 1'b1;
        e.g[occ[j]] = 1'b1;
        e.d[j*DW +: DW] = dat_a[occ[j]];
      end
    end
    e.b = v & ~e.g;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    for (int s = 0; s < N; s++) begin
      dst_a[s] = (s * 5 + 3) % N;
      dat_a[s] = 8'hEE;
    end
    send('0, tag);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Monitor: compare registered results one clock after each request.
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "out_valid", 64'(out_valid), 64'(e.v));
      chk(e.tag, "grant", 64'(grant), 64'(e.g));
      chk(e.tag, "blocked", 64'(blocked), 64'(e.b));
      for (int j = 0; j < N; j++)
        if (e.v[j]) chk(e.tag, "out_data", 64'(out_data[j*DW +: DW]), 64'(e.d[j*DW +: DW]));
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0;
    req_dest = '0;
    req_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "grant", 64'(grant), 64'd0);
    chk("R1", "blocked", 64'(blocked), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: lone requests to various destinations
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin dst_a[t] = 0; dat_a[t] = 8'h00; end
      dst_a[s] = N - 1 - s;
      dat_a[s] = 8'(8'hA0 + s);
      send(N'(1) << s, "R2");
    end
    idle("R8");

    // R3: identity permutation
    for (int s = 0; s < N; s++) begin dst_a[s] = s; dat_a[s] = 8'(8'h10 + s); end
    send('1, "R3");
    // R3: uniform shift by one
    for (int s = 0; s < N; s++) begin dst_a[s] = (s + 1) % N; dat_a[s] = 8'(8'h20 + s); end
    send('1, "R3");

    // R4: sources 2 and 6 both to destination 3; source 2 holds the even link
    for (int s = 0; s < N; s++) begin dst_a[s] = 0; dat_a[s] = 8'h00; end
    dst_a[2] = 3; dat_a[2] = 8'h42;
    dst_a[6] = 3; dat_a[6] = 8'h46;
    send(8'b0100_0100, "R4");
    // R4: everyone to destination 0, only one may pass
    for (int s = 0; s < N; s++) begin dst_a[s] = 0; dat_a[s] = 8'(8'h50 + s); end
    send('1, "R4");

    // R5: sources 0 and 4 with different labels collide in column 0
    for (int s = 0; s < N; s++) begin dst_a[s] = 0; dat_a[s] = 8'h00; end
    dst_a[0] = 0; dat_a[0] = 8'h60;
    dst_a[4] = 1; dat_a[4] = 8'h64;
    send(8'b0001_0001, "R5");
    // R5: reversal permutation
    for (int s = 0; s < N; s++) begin dst_a[s] = N - 1 - s; dat_a[s] = 8'(8'h70 + s); end
    send('1, "R5");

    // R6: partial request set with garbage labels on idle sources
    for (int s = 0; s < N; s++) begin dst_a[s] = (s * 3) % N; dat_a[s] = 8'(8'h80 + s); end
    send(8'b1010_0110, "R6");
    idle("R8");
    idle("R8");

    // R7: a mixed pattern with some collisions
    for (int s = 0; s < N; s++) begin dst_a[s] = (s * s) % N; dat_a[s] = 8'(8'h90 + s); end
    send('1, "R7");
    idle("R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL drain actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule